// File: doc/BRIEF.md
# Serial Boot-Stream Instruction-Cache Loader

At power-on this block reads a single serial bit stream out of a byte-wide boot ROM and turns it into complete instruction-cache lines. It drives the ROM address and moves on by one address per clock. A static 3-bit lane selector picks which of the eight ROM data bits carries the stream, so one ROM can hold eight separate boot images. Each bit is captured into a line register. Once a line's 293 bits are in, the block presents the line on a cache-array write port for exactly one cycle, together with its index.

A line carries eight 32-bit data words and its control fields: a 21-bit tag, a 6-bit address-space number, an address-space-match bit, a valid bit and 8 branch-history bits. The stream delivers the even data words first, then the tag and control bits, then the odd data words, and the branch-history bits last. Every field arrives least significant bit first. After 223 lines (7136 bytes of program), the block raises `load_done`, stops the ROM address and ignores the remaining stream bits. From that point it connects the diagnostic serial header straight through to the software-timed port. Until then the header lines are held idle.

The sequencer has three named states. `ST_FILL` captures one stream bit per clock. `ST_COMMIT` asserts the write strobe and, unless this is the last line, also captures bit 0 of the next line. `ST_DONE` is terminal. The transitions are: FILL to COMMIT when the 293rd bit of a line is captured; COMMIT to FILL when more lines remain; COMMIT to DONE after line 222. Reset puts the sequencer in `ST_FILL`.

Top module: `srom_fill_loader`

## Requirements
- R1: While `rst_n` is low: `rom_addr` is 0, `line_we` and `load_done` are 0, and both `diag_tx_pin` and `diag_rx_sw` are 1. A reset in the middle of a load restarts it from address 0 and line 0.
- R2: The first rising edge after reset release captures the stream bit at address 0. `rom_addr` then rises by one per clock, so after n edges it equals n, until the load completes.
- R3: The captured bit is `rom_data[lane_sel]`. The other seven data bits have no effect on the loaded lines.
- R4: Within a line, stream bits 0..127 fill data words 0, 2, 4, 6 (32 bits each, in that order). Bits 128..148 fill the tag, 149..154 the address-space number, bit 155 the address-space-match bit, and bit 156 the valid bit. Every field is LSB first.
- R5: Within a line, stream bits 157..284 fill data words 1, 3, 5, 7 (32 bits each, in that order), and bits 285..292 fill the branch-history byte, each LSB first. Data word k appears on `line_data[32k+31:32k]`.
- R6: `line_we` is high for exactly one cycle, right after edge 293·(L+1) counted from reset release, with `line_idx` = L. All field outputs hold line L during that cycle. The next line's first bit is captured on the following edge, so no cycle is lost between lines.
- R7: Exactly 223 lines (indices 0..222) are written. `load_done` rises one cycle after the last strobe and stays high. After that, `rom_addr` holds at 65339 and `line_we` stays low, whatever the remaining stream bits are.
- R8: While `load_done` is low, `diag_tx_pin` and `diag_rx_sw` are 1 whatever `diag_tx_sw` and `diag_rx_pin` do.
- R9: Once `load_done` is high, `diag_tx_pin` follows `diag_tx_sw` and `diag_rx_sw` follows `diag_rx_pin` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| lane_sel | input | 3 | Static choice of the ROM data bit that carries the stream |
| rom_addr | output | 16 | ROM address, one bit of stream per address |
| rom_data | input | 8 | ROM data byte for the current address |
| line_we | output | 1 | One-cycle cache write strobe |
| line_idx | output | 8 | Index of the line being written |
| line_data | output | 256 | Data words 0..7, word k at bits 32k+31:32k |
| line_tag | output | 21 | Tag field |
| line_asn | output | 6 | Address-space number |
| line_asm | output | 1 | Address-space-match bit |
| line_valid | output | 1 | Valid bit |
| line_bht | output | 8 | Branch-history bits |
| load_done | output | 1 | Whole stream consumed |
| diag_tx_sw | input | 1 | Transmit bit from the software-timed port |
| diag_tx_pin | output | 1 | Transmit line to the diagnostic header |
| diag_rx_pin | input | 1 | Receive line from the diagnostic header |
| diag_rx_sw | output | 1 | Receive bit to the software-timed port |

## Verification
Two functions share the commit cycle: the cache write of line L and the capture of the first stream bit of line L+1. Every line boundary provokes this, because the sequencer never stalls. The bench drives ROM patterns whose lane bits change from one address to the next and rebuilds each line from the stream. It then checks that the strobe lands exactly 293·(L+1) edges after reset, that the strobed fields are intact, and that bit 0 of the following line is correct. The full-length run also checks the last commit against the switch to `ST_DONE`. The write must happen there, the address must freeze, and no further strobe may appear.

// File: rtl/srom_pkg.sv
package srom_pkg;

    // field geometry of one cache line as delivered by the stream
    localparam int LW_W     = 32;
    localparam int NUM_LW   = 8;
    localparam int TAG_W    = 21;
    localparam int ASN_W    = 6;
    localparam int BHT_W    = 8;

    // bit offsets inside the assembled line (first stream bit = offset 0)
    localparam int OFF_EVEN = 0;
    localparam int OFF_TAG  = OFF_EVEN + (NUM_LW / 2) * LW_W;
    localparam int OFF_ASN  = OFF_TAG + TAG_W;
    localparam int OFF_ASM  = OFF_ASN + ASN_W;
    localparam int OFF_V    = OFF_ASM + 1;
    localparam int OFF_ODD  = OFF_V + 1;
    localparam int OFF_BHT  = OFF_ODD + (NUM_LW / 2) * LW_W;
    localparam int LINE_BITS = OFF_BHT + BHT_W;

    typedef enum logic [1:0] {
        ST_FILL   = 2'd0,
        ST_COMMIT = 2'd1,
        ST_DONE   = 2'd2
    } fill_state_e;

endpackage

// File: rtl/srom_lane_pick.sv
module srom_lane_pick #(
    parameter int LANES = 8
) (
    input  logic [LANES-1:0]         rom_data,
    input  logic [$clog2(LANES)-1:0] sel,
    output logic                     bit_o
);
    always_comb begin
        bit_o = 1'b0;
        for (int i = 0; i < LANES; i++) begin
            if (sel == ($clog2(LANES))'(i)) begin
                bit_o = rom_data[i];
            end
        end
    end
endmodule

// File: rtl/srom_line_asm.sv
module srom_line_asm
    import srom_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 shift_en,
    input  logic                 bit_in,
    output logic [NUM_LW*LW_W-1:0] data_o,
    output logic [TAG_W-1:0]     tag_o,
    output logic [ASN_W-1:0]     asn_o,
    output logic                 asm_o,
    output logic                 valid_o,
    output logic [BHT_W-1:0]     bht_o
);
    logic [LINE_BITS-1:0] line_q;

    // new bit enters at the top; after a full line the first bit sits at 0
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= '0;
        end else if (shift_en) begin
            line_q <= {bit_in, line_q[LINE_BITS-1:1]};
        end
    end

    // even words come before the control fields, odd words after
    for (genvar k = 0; k < NUM_LW; k++) begin : g_word
        localparam int BASE = ((k % 2) == 0) ? OFF_EVEN : OFF_ODD;
        localparam int POS  = BASE + (k / 2) * LW_W;
        assign data_o[k*LW_W +: LW_W] = line_q[POS +: LW_W];
    end

    assign tag_o   = line_q[OFF_TAG +: TAG_W];
    assign asn_o   = line_q[OFF_ASN +: ASN_W];
    assign asm_o   = line_q[OFF_ASM];
    assign valid_o = line_q[OFF_V];
    assign bht_o   = line_q[OFF_BHT +: BHT_W];
endmodule

// File: rtl/srom_fill_seq.sv
module srom_fill_seq
    import srom_pkg::*;
#(
    parameter int NUM_LINES = 223,
    parameter int ADDR_W    = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    output logic                         shift_en,
    output logic [ADDR_W-1:0]            addr_o,
    output logic [$clog2(NUM_LINES)-1:0] idx_o,
    output logic                         we_o,
    output logic                         done_o
);
    localparam int IDX_W = $clog2(NUM_LINES);
    localparam int CNT_W = $clog2(LINE_BITS);

    fill_state_e          state_q, state_d;
    logic [CNT_W-1:0]     bit_q, bit_d;
    logic [IDX_W-1:0]     line_q, line_d;
    logic [ADDR_W-1:0]    addr_q, addr_d;
    logic                 last_line;

    assign last_line = (line_q == IDX_W'(NUM_LINES - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FILL;
            bit_q   <= '0;
            line_q  <= '0;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            bit_q   <= bit_d;
            line_q  <= line_d;
            addr_q  <= addr_d;
        end
    end

    // next state and counters
    always_comb begin
        state_d = state_q;
        bit_d   = bit_q;
        line_d  = line_q;
        addr_d  = addr_q;
        unique case (state_q)
            ST_FILL: begin
                addr_d = addr_q + 1'b1;
                if (bit_q == CNT_W'(LINE_BITS - 1)) begin
                    bit_d   = '0;
                    state_d = ST_COMMIT;
                end else begin
                    bit_d = bit_q + 1'b1;
                end
            end
            ST_COMMIT: begin
                if (last_line) begin
                    state_d = ST_DONE;
                end else begin
                    addr_d  = addr_q + 1'b1;
                    bit_d   = CNT_W'(1);
                    line_d  = line_q + 1'b1;
                    state_d = ST_FILL;
                end
            end
            ST_DONE: begin
                state_d = ST_DONE;
            end
            default: begin
                state_d = ST_FILL;
            end
        endcase
    end

    // outputs
    always_comb begin
        shift_en = 1'b0;
        we_o     = 1'b0;
        done_o   = 1'b0;
        unique case (state_q)
            ST_FILL:   shift_en = 1'b1;
            ST_COMMIT: begin
                we_o     = 1'b1;
                shift_en = !last_line;
            end
            ST_DONE:   done_o = 1'b1;
            default:   shift_en = 1'b0;
        endcase
    end

    assign addr_o = addr_q;
    assign idx_o  = line_q;

    // R2
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (addr_o == $past(addr_o) + 1'b1));

    // R6
    we_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_o |=> !we_o);

    // R7
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_o |-> (idx_o <= IDX_W'(NUM_LINES - 1)));

    // R7
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (done_o && !we_o && $stable(addr_o)));
endmodule

// File: rtl/srom_fill_loader.sv
module srom_fill_loader
    import srom_pkg::*;
#(
    parameter int NUM_LINES   = 223,
    parameter int STREAM_BITS = 65536,
    parameter int LANES       = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [$clog2(LANES)-1:0]       lane_sel,
    output logic [$clog2(STREAM_BITS)-1:0] rom_addr,
    input  logic [LANES-1:0]               rom_data,
    output logic                           line_we,
    output logic [$clog2(NUM_LINES)-1:0]   line_idx,
    output logic [NUM_LW*LW_W-1:0]         line_data,
    output logic [TAG_W-1:0]               line_tag,
    output logic [ASN_W-1:0]               line_asn,
    output logic                           line_asm,
    output logic                           line_valid,
    output logic [BHT_W-1:0]               line_bht,
    output logic                           load_done,
    input  logic                           diag_tx_sw,
    output logic                           diag_tx_pin,
    input  logic                           diag_rx_pin,
    output logic                           diag_rx_sw
);
    localparam int ADDR_W = $clog2(STREAM_BITS);

    logic serial_bit;
    logic shift_en;

    srom_lane_pick #(.LANES(LANES)) u_pick (
        .rom_data (rom_data),
        .sel      (lane_sel),
        .bit_o    (serial_bit)
    );

    srom_fill_seq #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .addr_o   (rom_addr),
        .idx_o    (line_idx),
        .we_o     (line_we),
        .done_o   (load_done)
    );

    srom_line_asm u_asm (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .bit_in   (serial_bit),
        .data_o   (line_data),
        .tag_o    (line_tag),
        .asn_o    (line_asn),
        .asm_o    (line_asm),
        .valid_o  (line_valid),
        .bht_o    (line_bht)
    );

    // header lines idle high until the stream has been consumed
    always_comb begin
        if (load_done) begin
            diag_tx_pin = diag_tx_sw;
            diag_rx_sw  = diag_rx_pin;
        end else begin
            diag_tx_pin = 1'b1;
            diag_rx_sw  = 1'b1;
        end
    end

    // R8
    diag_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_done |-> (diag_tx_pin && diag_rx_sw));

    // R9
    diag_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |-> (diag_tx_pin == diag_tx_sw && diag_rx_sw == diag_rx_pin));
endmodule

// File: tb/srom_fill_loader_tb.sv
module srom_fill_loader_tb;
    localparam int LBITS  = 293;
    localparam int NLINES = 223;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   lane_sel = 3'd0;
    logic [15:0]  rom_addr;
    logic [7:0]   rom_data;
    logic         line_we;
    logic [7:0]   line_idx;
    logic [255:0] line_data;
    logic [20:0]  line_tag;
    logic [5:0]   line_asn;
    logic         line_asm, line_valid;
    logic [7:0]   line_bht;
    logic         load_done;
    logic         diag_tx_sw = 1'b0, diag_rx_pin = 1'b0;
    logic         diag_tx_pin, diag_rx_sw;
    logic [1:0]   mode_r = 2'd0;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    srom_fill_loader u_dut (
        .clk(clk), .rst_n(rst_n), .lane_sel(lane_sel), .rom_addr(rom_addr),
        .rom_data(rom_data), .line_we(line_we), .line_idx(line_idx),
        .line_data(line_data), .line_tag(line_tag), .line_asn(line_asn),
        .line_asm(line_asm), .line_valid(line_valid), .line_bht(line_bht),
        .load_done(load_done), .diag_tx_sw(diag_tx_sw), .diag_tx_pin(diag_tx_pin),
        .diag_rx_pin(diag_rx_pin), .diag_rx_sw(diag_rx_sw)
    );

    // ROM model: mode 0 hash, 1 all ones, 2 all zeros, 3 hash on chosen lane, others inverted
    function automatic logic [7:0] rom_model(input logic [1:0] m, input logic [2:0] ln,
                                             input logic [15:0] a);
        logic [7:0] h, r;
        h = a[7:0] ^ {a[12:8], a[15:13]} ^ {a[3:0], a[7:4]} ^ 8'h3C ^ {3'b0, a[9:5]};
        case (m)
            2'd0: r = h;
            2'd1: r = 8'hFF;
            2'd2: r = 8'h00;
            default: begin r = ~h; r[ln] = h[ln]; end
        endcase
        return r;
    endfunction

    always_comb rom_data = rom_model(mode_r, lane_sel, rom_addr);

    typedef struct packed {
        logic [2:0] lane;
        logic [1:0] mode;
        logic [7:0] lines;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{3'd0, 2'd0, 8'd3}, '{3'd1, 2'd3, 8'd3}, '{3'd2, 2'd1, 8'd2},
        '{3'd3, 2'd2, 8'd2}, '{3'd4, 2'd3, 8'd3}, '{3'd5, 2'd0, 8'd2},
        '{3'd6, 2'd3, 8'd2}, '{3'd7, 2'd3, 8'd3}
    };

    task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic build_exp(input logic [1:0] m, input logic [2:0] ln, input int line,
                             output logic [255:0] d, output logic [20:0] t,
                             output logic [5:0] s, output logic am, output logic v,
                             output logic [7:0] b);
        d = '0; t = '0; s = '0; am = 1'b0; v = 1'b0; b = '0;
        for (int p = 0; p < LBITS; p++) begin
            logic [7:0] byt;
            logic       bt;
            byt = rom_model(m, ln, 16'(line * LBITS + p));
            bt  = byt[ln];
            if (p < 128)      d[(2 * (p / 32)) * 32 + p % 32] = bt;
            else if (p < 149) t[p - 128] = bt;
            else if (p < 155) s[p - 149] = bt;
            else if (p == 155) am = bt;
            else if (p == 156) v = bt;
            else if (p < 285) d[(2 * ((p - 157) / 32) + 1) * 32 + (p - 157) % 32] = bt;
            else              b[p - 285] = bt;
        end
    endtask

    task automatic check_line(input logic [1:0] m, input logic [2:0] ln, input int line);
        logic [255:0] d;
        logic [20:0]  t;
        logic [5:0]   s;
        logic         am, v;
        logic [7:0]   b;
        build_exp(m, ln, line, d, t, s, am, v, b);
        for (int k = 0; k < 8; k++) begin
            if (k % 2 == 0) check("R3/R4 even word", 256'(line_data[k*32 +: 32]), 256'(d[k*32 +: 32]));
            else            check("R3/R5 odd word",  256'(line_data[k*32 +: 32]), 256'(d[k*32 +: 32]));
        end
        check("R4 tag",   256'(line_tag),   256'(t));
        check("R4 asn",   256'(line_asn),   256'(s));
        check("R4 asm",   256'(line_asm),   256'(am));
        check("R4 valid", 256'(line_valid), 256'(v));
        check("R5 bht",   256'(line_bht),   256'(b));
        check("R6 line index", 256'(line_idx), 256'(line));
    endtask

    task automatic do_reset;
        rst_n = 1'b0;
        diag_tx_sw = 1'b0;
        diag_rx_pin = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 addr in reset", 256'(rom_addr), 256'(0));
        check("R1 we in reset", 256'(line_we), 256'(0));
        check("R1 done in reset", 256'(load_done), 256'(0));
        check("R1 diag idle in reset", 256'({diag_tx_pin, diag_rx_sw}), 256'(2'b11));
        rst_n = 1'b1;
    endtask

    task automatic run_load(input logic [2:0] ln, input logic [1:0] m, input int nlines,
                            input bit full);
        int got = 0;
        int cyc = 0;
        lane_sel = ln;
        mode_r = m;
        do_reset();
        while (got < nlines) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            check("R2 addr step", 256'(rom_addr), 256'(cyc));
            check("R8 diag idle", 256'({diag_tx_pin, diag_rx_sw}), 256'(2'b11));
            if (!full || got == NLINES - 1)
                check("R7 done low while loading", 256'(load_done), 256'(0));
            if (line_we) begin
                check("R6 strobe timing", 256'(cyc), 256'(LBITS * (got + 1)));
                check_line(m, ln, got);
                got++;
            end
            diag_tx_sw  = cyc[0];
            diag_rx_pin = cyc[1];
        end
        if (full) begin
            @(posedge clk);
            @(negedge clk);
            check("R7 done after last", 256'(load_done), 256'(1));
            for (int i = 0; i < 40; i++) begin
                @(posedge clk);
                @(negedge clk);
                check("R7 addr frozen", 256'(rom_addr), 256'(NLINES * LBITS));
                check("R7 no strobe", 256'(line_we), 256'(0));
                check("R7 done sticky", 256'(load_done), 256'(1));
            end
            for (int i = 0; i < 4; i++) begin
                diag_tx_sw  = i[0];
                diag_rx_pin = i[1];
                #1;
                check("R9 tx pass", 256'(diag_tx_pin), 256'(i[0]));
                check("R9 rx pass", 256'(diag_rx_sw), 256'(i[1]));
                @(negedge clk);
            end
        end
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        n_bad++;
        $display("FAIL R7 watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        // table of lane/pattern vectors, each with a reset mid-stream from the previous one (R1)
        for (int i = 0; i < 8; i++) begin
            run_load(VECS[i].lane, VECS[i].mode, int'(VECS[i].lines), 1'b0);
        end
        // full stream, last commit against handover (R6, R7, R9)
        run_load(3'd6, 2'd3, NLINES, 1'b1);
        // reset after completion restarts the load (R1)
        run_load(3'd2, 2'd0, 1, 1'b0);
        summary();
        $finish;
    end
endmodule